// File: doc/BRIEF.md
# 32-bit Integer Arithmetic/Logic Unit

This block is the combinational integer execute unit for a simple load/store pipeline. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result together with a zero flag and a signed-overflow flag. The decode stage has already done all immediate extension and instruction decoding, so only the operation code reaches this block. The block has no clock: its outputs follow its inputs in the same cycle.

One ripple adder serves every arithmetic operation. When the operation is a subtract or a compare, the adder inverts the second operand and forces its carry-in to one. Both compare operations read their answer from that same difference:
- The signed compare corrects the sign bit with the overflow condition.
- The unsigned compare uses the inverted carry-out.

The block only reports overflow. Trapping on overflow is left to the surrounding pipeline.

Top module: `int_alu`

## Requirements
- R1: Operation codes 0 (add) and 1 (add, no trap) give a result of A+B modulo 2^32.
- R2: Operation codes 2 (subtract) and 3 (subtract, no trap) give a result of A-B modulo 2^32.
- R3: The overflow flag may be 1 only for operation codes 0 and 2. Codes 1, 3, 12 and 13 never raise it, whatever the operands.
- R4: For code 0, overflow is 1 exactly when A and B have the same sign bit (bit 31) and the result's sign bit differs from it.
- R5: For code 2, overflow is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R6: Code 12 (signed less-than) gives 1 when A < B as two's-complement numbers and 0 otherwise. Bits 31..1 of the result are zero. The answer is correct even when the internal difference overflows.
- R7: Code 13 (unsigned less-than) gives 1 when A < B as unsigned numbers and 0 otherwise. Bits 31..1 of the result are zero.
- R8: Codes 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of A and B, in that order.
- R9: The zero flag is 1 exactly when all 32 result bits are 0, for every operation code.
- R10: Codes 8 to 11, 14 and 15 give a result of 0 with overflow at 0, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow for codes 0 and 2 |

## Verification
The hardest case to reach from the ports is a signed compare whose internal difference overflows. In that case the raw sign bit of the difference gives the wrong answer. Random operands reach it only about a quarter of the time, and they almost never reach it at the range extremes. The stimulus therefore crosses every operation code with every ordered pair drawn from 0, 1, -1, the largest positive value and the most negative value, which produces these overflowing compares on purpose. Random operands follow for broader coverage.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_NOR  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd12;
  localparam logic [3:0] OP_SLTU = 4'd13;

  // Operations that run the adder in difference mode
  function automatic logic op_uses_sub(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carry;

  assign b_eff    = b_i ^ {WIDTH{sub_i}};
  assign carry[0] = sub_i;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_fa
    assign sum_o[gi]    = a_i[gi] ^ b_eff[gi] ^ carry[gi];
    assign carry[gi+1]  = (a_i[gi] & b_eff[gi]) | (a_i[gi] & carry[gi]) | (b_eff[gi] & carry[gi]);
  end

  assign cout_o = carry[WIDTH];
  // Same-sign inputs to the adder producing an opposite-sign sum
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] logic_y;
  logic             cout;
  logic             raw_ovf;
  logic             sub_en;
  logic             lt_signed;
  logic             lt_unsigned;

  assign sub_en = op_uses_sub(op_i);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_en),
    .sum_o (sum),
    .cout_o(cout),
    .ovf_o (raw_ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(op_i[1:0]),
    .y_o  (logic_y)
  );

  // Sign of difference corrected by overflow; unsigned borrow is inverted carry
  assign lt_signed   = sum[MSB] ^ raw_ovf;
  assign lt_unsigned = ~cout;

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        result_o = sum;
        ovf_o    = raw_ovf;
      end
      OP_ADDU, OP_SUBU:              result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: result_o = logic_y;
      OP_SLT:                        result_o = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:                       result_o = {{(WIDTH-1){1'b0}}, lt_unsigned};
      default: begin
        result_o = '0;
        ovf_o    = 1'b0;
      end
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    // R3
    no_overflow_chk: assert (!ovf_o || op_i == OP_ADD || op_i == OP_SUB);
    // R4
    add_ovf_sign_chk: assert (!(op_i == OP_ADD && ovf_o) ||
                              (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]));
    // R5
    sub_ovf_sign_chk: assert (!(op_i == OP_SUB && ovf_o) ||
                              (a_i[MSB] != b_i[MSB] && result_o[MSB] != a_i[MSB]));
    // R6 R7
    lt_width_chk: assert (!(op_i == OP_SLT || op_i == OP_SLTU) || result_o[MSB:1] == '0);
    // R10
    unused_quiet_chk: assert (!(op_i inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd14, 4'd15}) ||
                              (zero_o && !ovf_o));
  end
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         ovf;
    logic         zero;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   op = '0;
  logic [W-1:0] result;
  logic         zero;
  logic         ovf;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  int_alu #(.WIDTH(W)) u_dut (
    .a_i     (a),
    .b_i     (b),
    .op_i    (op),
    .result_o(result),
    .zero_o  (zero),
    .ovf_o   (ovf)
  );

  function automatic string res_tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:             return "R1";
      4'd2, 4'd3:             return "R2";
      4'd4, 4'd5, 4'd6, 4'd7: return "R8";
      4'd12:                  return "R6";
      4'd13:                  return "R7";
      default:                return "R10";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [3:0] o);
    if (o == 4'd0) return "R4";
    if (o == 4'd2) return "R5";
    return "R3";
  endfunction

  function automatic item_t model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] o);
    item_t  it;
    longint sx, sy, s;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    it.a = x; it.b = y; it.op = o; it.ovf = 1'b0; it.res = '0;
    case (o)
      4'd0: begin s = sx + sy; it.res = x + y; it.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd1: it.res = x + y;
      4'd2: begin s = sx - sy; it.res = x - y; it.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd3: it.res = x - y;
      4'd4: it.res = x & y;
      4'd5: it.res = x | y;
      4'd6: it.res = x ^ y;
      4'd7: it.res = ~(x | y);
      4'd12: it.res = (sx < sy) ? 32'd1 : 32'd0;
      4'd13: it.res = (x < y) ? 32'd1 : 32'd0;
      default: it.res = '0;
    endcase
    it.zero = (it.res == '0);
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] o);
    @(posedge clk);
    a  <= x;
    b  <= y;
    op <= o;
    exp_q.push_back(model(x, y, o));
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (result !== e.res) begin
        n_fail++;
        $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                 res_tag(e.op), e.op, e.a, e.b, result, e.res);
      end
      n_checks++;
      if (ovf !== e.ovf) begin
        n_fail++;
        $display("FAIL %s op=%0d a=%h b=%h ovf actual=%b expected=%b",
                 ovf_tag(e.op), e.op, e.a, e.b, ovf, e.ovf);
      end
      n_checks++;
      if (zero !== e.zero) begin
        n_fail++;
        $display("FAIL R9 op=%0d a=%h b=%h zero actual=%b expected=%b",
                 e.op, e.a, e.b, zero, e.zero);
      end
    end
  end

  initial begin
    logic [W-1:0] corners[5];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000;

    repeat (3) @(posedge clk);
    rst_ni <= 1'b1;
    @(posedge clk);

    // Reset state: all-zero operands with add, expect zero result and zero flag (R1, R9)
    drive('0, '0, 4'd0);

    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corners[i], corners[j], 4'(o));

    // Overflowing signed compares (R6)
    drive(32'h8000_0000, 32'h0000_0001, 4'd12);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd12);

    for (int k = 0; k < 300; k++)
      for (int o = 0; o < 16; o++)
        drive($urandom, $urandom, 4'(o));

    // Equal operands: compares return 0, difference is zero (R2, R6, R7, R9)
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] v;
      v = $urandom;
      drive(v, v, 4'd3);
      drive(v, v, 4'd12);
      drive(v, v, 4'd13);
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule